// File: doc/BRIEF.md
# Read-Started Converter Bus Interface

This block is the digital front end of a 12-bit successive-approximation converter. A processor starts each conversion by reading it, not by writing to it. The channel number and the differential and bipolar settings come from dedicated select pins, and the block captures them at the moment a conversion starts. Each conversion takes a fixed schedule on the converter clock: three track clocks, then twelve bit trials, most significant bit first, against a comparator input.

Two bus behaviours are available, chosen by a mode pin that the block samples only while no conversion is running.

- **Wait-state mode:** a ready output is pulled low while chip select is low. It is released when the conversion completes, so the processor stalls until the fresh result sits on the data pins.
- **Pipelined mode:** the ready output never stalls. Every starting read returns the result of the previous conversion and launches the next one.

Either mode can be used with a full-width bus or with two byte reads under a high-byte enable. A read with that enable high never starts a conversion.

Top module: `adcr_read_if`

## Requirements
- R1: When `cs_n` and `rd_n` are first seen low together at a clock edge, `hben` is 0 and the block is idle, a conversion starts. `busy_n` is low from that edge for exactly 15 clocks (3 track and 12 trial clocks) and is high again after the 15th following edge.
- R2: `hold` is low during the first 3 clocks of a conversion and high during the 12 trial clocks. During each trial, `trial_code` is the bits already decided plus the bit under test, working from bit 11 down to bit 0. `cmp_in` = 1 keeps the tested bit. The final result equals the analog level that the comparator encodes.
- R3: `sel_chan`, `sel_diff` and `sel_bip` are captured onto `conv_chan`, `conv_diff` and `conv_bip` at the start edge. Those outputs do not change while the conversion runs, even if the select pins change.
- R4: A read strobe with `hben` = 1 never starts a conversion.
- R5: A starting strobe that arrives during a conversion does not restart it and does not recapture the configuration. `start_ovr` is 1 in the cycle the strobe is seen.
- R6: `dout_en` is 1 while `cs_n` and `rd_n` are both low. With `hben` = 0, `dout` is the 12-bit result. With `hben` = 1, `dout[3:0]` holds result bits 11..8 and `dout[7:4]` is 0. `dout[11:8]` always carries result bits 11..8.
- R7: The result register holds 0 after reset and changes only when a conversion completes. A starting read therefore returns the previous result, and the first read after reset returns 0.
- R8: With `wait_mode` = 1, `rdy_n` is low whenever `cs_n` and `hben` are low and the current select cycle has not yet completed a conversion. `rdy_n` rises together with `busy_n`, and the new result is then on `dout`. With `wait_mode` = 0, `rdy_n` stays 1.
- R9: `wait_mode` is sampled only while idle. A change during a conversion does not affect `rdy_n` until that conversion has finished.
- R10: In two-byte pipelined use, the sequence low-byte read (starts a conversion), high-byte read, low-byte read returns the previous low byte, then the new upper nibble with zero fill, then the new low byte. The last read also starts the next conversion.
- R11: After reset, `busy_n` = 1, `rdy_n` = 1, `hold` = 0 and `start_ovr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte enable; 1 blocks starts and selects the upper nibble |
| wait_mode | input | 1 | 1 = wait-state behaviour, 0 = pipelined behaviour |
| sel_chan | input | 3 | Channel select pins |
| sel_diff | input | 1 | Differential select pin |
| sel_bip | input | 1 | Bipolar select pin |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial level |
| busy_n | output | 1 | Low while a conversion runs |
| rdy_n | output | 1 | Ready output for wait-state mode, low = stall |
| dout | output | 12 | Read data |
| dout_en | output | 1 | Data output enable |
| hold | output | 1 | 1 = sample held, 0 = tracking |
| trial_code | output | 12 | Code under test for the trial DAC |
| conv_chan | output | 3 | Channel captured for the current conversion |
| conv_diff | output | 1 | Differential setting captured at start |
| conv_bip | output | 1 | Bipolar setting captured at start |
| start_ovr | output | 1 | Starting strobe arrived during a conversion |

## Verification
Inputs change 2 ns after a falling clock edge, so the start edge is the next rising edge. Counting cycles from that drive point:

- `busy_n` is low at the 1st through 15th following falling edges and high at the 16th.
- `hold` is high from the 4th through the 15th.
- `rdy_n` in wait-state mode rises at the 16th, together with the fresh result.

The bench checks each of these at exactly those points. Read data, and `start_ovr` and `rdy_n` as they respond to select, are combinational. Expected read data is queued when the read is driven, and the monitor compares it at the next falling edge. `start_ovr` and `rdy_n` are checked 1 ns after the drive, before any clock edge.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int CHAN_W = 3;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              diff;
    logic              bip;
  } adcr_cfg_t;
endpackage

// File: rtl/adcr_strobe_det.sv
module adcr_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic hben,
  output logic rd_act,
  output logic start_req
);
  logic rd_act_q;
  logic rd_act_d;

  assign rd_act    = ~cs_n & ~rd_n;
  assign start_req = rd_act & ~rd_act_q & ~hben;
  assign rd_act_d  = rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_act_q <= 1'b0;
    else        rd_act_q <= rd_act_d;
  end
endmodule

// File: rtl/adcr_sar_seq.sv
module adcr_sar_seq
  import adcr_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int TRACK_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  adcr_cfg_t        cfg_in,
  input  logic             cmp_in,
  output logic             conv,
  output logic             hold,
  output logic             done,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] result,
  output adcr_cfg_t        cfg_q
);
  localparam int TOTAL = TRACK_CLKS + RES_W;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             conv_q, conv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] sar_q, sar_d, sar_nxt;
  logic [RES_W-1:0] res_q, res_d;
  adcr_cfg_t        cfg_r, cfg_d;
  logic [CNT_W-1:0] step_c;
  logic [CNT_W-1:0] bit_idx;
  logic [RES_W-1:0] trial_bit;
  logic             last;

  assign hold      = conv_q && (cnt_q >= CNT_W'(TRACK_CLKS));
  assign step_c    = cnt_q - CNT_W'(TRACK_CLKS);
  assign bit_idx   = CNT_W'(RES_W - 1) - step_c;
  assign trial_bit = hold ? (RES_W'(1) << bit_idx) : '0;
  assign sar_nxt   = sar_q | (cmp_in ? trial_bit : '0);
  assign last      = conv_q && (cnt_q == CNT_W'(TOTAL - 1));

  always_comb begin
    conv_d = conv_q;
    cnt_d  = cnt_q;
    sar_d  = sar_q;
    res_d  = res_q;
    cfg_d  = cfg_r;
    if (start) begin
      conv_d = 1'b1;
      cnt_d  = '0;
      sar_d  = '0;
      cfg_d  = cfg_in;
    end else if (conv_q) begin
      if (hold) sar_d = sar_nxt;
      if (last) begin
        conv_d = 1'b0;
        res_d  = sar_nxt;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      cnt_q  <= '0;
      sar_q  <= '0;
      res_q  <= '0;
      cfg_r  <= '0;
    end else begin
      conv_q <= conv_d;
      cnt_q  <= cnt_d;
      sar_q  <= sar_d;
      res_q  <= res_d;
      cfg_r  <= cfg_d;
    end
  end

  assign conv       = conv_q;
  assign done       = last;
  assign trial_code = sar_q | trial_bit;
  assign result     = res_q;
  assign cfg_q      = cfg_r;
endmodule

// File: rtl/adcr_bus_port.sv
module adcr_bus_port #(
  parameter int RES_W = 12,
  parameter int LO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             hben,
  input  logic             rd_act,
  input  logic             wait_mode,
  input  logic             conv,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  output logic [RES_W-1:0] dout,
  output logic             dout_en,
  output logic             rdy_n
);
  localparam int HI_W = RES_W - LO_W;

  logic mode_q, mode_d;
  logic seen_q, seen_d;

  always_comb begin
    mode_d = mode_q;
    if (!conv) mode_d = wait_mode;
    seen_d = seen_q;
    if (done)      seen_d = 1'b1;
    else if (cs_n) seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      seen_q <= seen_d;
    end
  end

  assign rdy_n   = ~(mode_q & ~cs_n & ~hben & ~seen_q);
  assign dout_en = rd_act;

  assign dout[RES_W-1:LO_W] = result[RES_W-1:LO_W];
  generate
    if (HI_W < LO_W) begin : g_pad
      assign dout[LO_W-1:0] = hben ? {{(LO_W-HI_W){1'b0}}, result[RES_W-1:LO_W]}
                                   : result[LO_W-1:0];
    end else begin : g_nopad
      assign dout[LO_W-1:0] = hben ? result[RES_W-1:LO_W] : result[LO_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/adcr_read_if.sv
module adcr_read_if
  import adcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              hben,
  input  logic              wait_mode,
  input  logic [CHAN_W-1:0] sel_chan,
  input  logic              sel_diff,
  input  logic              sel_bip,
  input  logic              cmp_in,
  output logic              busy_n,
  output logic              rdy_n,
  output logic [11:0]       dout,
  output logic              dout_en,
  output logic              hold,
  output logic [11:0]       trial_code,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_diff,
  output logic              conv_bip,
  output logic              start_ovr
);
  localparam int RES_W      = 12;
  localparam int TRACK_CLKS = 3;
  localparam int LO_W       = 8;

  logic       rst_s1, rst_s2;
  logic       rd_act, start_req, start, conv, done;
  logic [RES_W-1:0] result;
  adcr_cfg_t  cfg_in, cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  adcr_strobe_det u_strobe (
    .clk       (clk),
    .rst_n     (rst_s2),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .hben      (hben),
    .rd_act    (rd_act),
    .start_req (start_req)
  );

  assign start     = start_req & ~conv;
  assign start_ovr = start_req & conv;

  assign cfg_in.chan = sel_chan;
  assign cfg_in.diff = sel_diff;
  assign cfg_in.bip  = sel_bip;

  adcr_sar_seq #(.RES_W(RES_W), .TRACK_CLKS(TRACK_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s2),
    .start      (start),
    .cfg_in     (cfg_in),
    .cmp_in     (cmp_in),
    .conv       (conv),
    .hold       (hold),
    .done       (done),
    .trial_code (trial_code),
    .result     (result),
    .cfg_q      (cfg_q)
  );

  adcr_bus_port #(.RES_W(RES_W), .LO_W(LO_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_s2),
    .cs_n      (cs_n),
    .hben      (hben),
    .rd_act    (rd_act),
    .wait_mode (wait_mode),
    .conv      (conv),
    .done      (done),
    .result    (result),
    .dout      (dout),
    .dout_en   (dout_en),
    .rdy_n     (rdy_n)
  );

  assign busy_n    = ~conv;
  assign conv_chan = cfg_q.chan;
  assign conv_diff = cfg_q.diff;
  assign conv_bip  = cfg_q.bip;
endmodule

// File: rtl/adcr_read_if_chk.sv
module adcr_read_if_chk #(
  parameter int RES_W      = 12,
  parameter int TRACK_CLKS = 3,
  parameter int LO_W       = 8,
  parameter int CHAN_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              hben,
  input logic              busy_n,
  input logic              rdy_n,
  input logic [RES_W-1:0]  dout,
  input logic              dout_en,
  input logic              hold,
  input logic [CHAN_W-1:0] conv_chan,
  input logic              conv_diff,
  input logic              conv_bip,
  input logic              start_ovr
);
  localparam int TOTAL = TRACK_CLKS + RES_W;
  localparam int HI_W  = RES_W - LO_W;

  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= 0;
    else if (!busy_n) low_cnt <= low_cnt + 1;
    else              low_cnt <= 0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_cnt == TOTAL)); // R1
  AST_HOLD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !busy_n); // R2
  AST_TRACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> !hold); // R2
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && $past(!busy_n)) |-> $stable({conv_chan, conv_diff, conv_bip})); // R3
  AST_HBEN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && hben) |=> busy_n); // R4
  AST_OVR_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ovr |=> $stable({conv_chan, conv_diff, conv_bip})); // R5
  AST_HI_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && hben) |-> (dout[LO_W-1:HI_W] == '0)); // R6
  AST_RDY_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> (!cs_n && !hben)); // R8
endmodule

bind adcr_read_if adcr_read_if_chk #(.RES_W(12), .TRACK_CLKS(3), .LO_W(8), .CHAN_W(3)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .hben      (hben),
  .busy_n    (busy_n),
  .rdy_n     (rdy_n),
  .dout      (dout),
  .dout_en   (dout_en),
  .hold      (hold),
  .conv_chan (conv_chan),
  .conv_diff (conv_diff),
  .conv_bip  (conv_bip),
  .start_ovr (start_ovr)
);

// File: tb/adcr_read_if_tb.sv
`timescale 1ns/1ps
module adcr_read_if_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, hben, wait_mode;
  logic [2:0]  sel_chan;
  logic        sel_diff, sel_bip;
  logic        cmp_in;
  logic        busy_n, rdy_n, dout_en, hold;
  logic [11:0] dout, trial_code;
  logic [2:0]  conv_chan;
  logic        conv_diff, conv_bip, start_ovr;

  logic [11:0] target;
  logic        chk_req;
  int          total = 0;
  int          bad   = 0;
  int          wd    = 0;

  logic [11:0] q_val[$];
  logic [11:0] q_mask[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  adcr_read_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .wait_mode(wait_mode), .sel_chan(sel_chan), .sel_diff(sel_diff),
    .sel_bip(sel_bip), .cmp_in(cmp_in), .busy_n(busy_n), .rdy_n(rdy_n),
    .dout(dout), .dout_en(dout_en), .hold(hold), .trial_code(trial_code),
    .conv_chan(conv_chan), .conv_diff(conv_diff), .conv_bip(conv_bip),
    .start_ovr(start_ovr)
  );

  // comparator model: input level is target
  assign cmp_in = (trial_code <= target);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #2;
    chk_req = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expect_read(input logic [11:0] v, input logic [11:0] m, input string tag);
    q_val.push_back(v);
    q_mask.push_back(m);
    q_tag.push_back(tag);
    chk_req = 1'b1;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (chk_req && q_val.size() > 0) begin
      logic [11:0] v, m;
      string       t;
      v = q_val.pop_front();
      m = q_mask.pop_front();
      t = q_tag.pop_front();
      chk({t, " dout_en"}, {31'd0, dout_en}, 32'd1);
      chk(t, {20'd0, dout & m}, {20'd0, v & m});
    end
  end

  task automatic start_read(input logic [11:0] v, input logic [11:0] m, input string tag);
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    expect_read(v, m, tag);
  endtask

  task automatic finish_conv();
    for (int n = 1; n <= 16; n++) begin
      cyc();
      if (n == 1) begin cs_n = 1'b1; rd_n = 1'b1; end
      if (n == 15) chk("R1 busy before end", {31'd0, busy_n}, 32'd0);
      if (n == 16) chk("R1 busy released", {31'd0, busy_n}, 32'd1);
    end
  endtask

  task automatic idle_gap();
    cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    cyc();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0; wait_mode = 1'b0;
    sel_chan = 3'd0; sel_diff = 1'b0; sel_bip = 1'b0; target = 12'h000; chk_req = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R11 reset state
    chk("R11 busy_n", {31'd0, busy_n}, 32'd1);
    chk("R11 rdy_n", {31'd0, rdy_n}, 32'd1);
    chk("R11 hold", {31'd0, hold}, 32'd0);
    chk("R11 start_ovr", {31'd0, start_ovr}, 32'd0);

    // first conversion: init read returns 0 (R7), timing R1, R2, config R3, overrun R5
    target = 12'hA5C; sel_chan = 3'd5; sel_diff = 1'b1; sel_bip = 1'b0;
    start_read(12'h000, 12'hFFF, "R7 init read");
    for (int n = 1; n <= 16; n++) begin
      cyc();
      chk("R1 busy window", {31'd0, busy_n}, (n <= 15) ? 32'd0 : 32'd1);
      chk("R2 hold window", {31'd0, hold}, (n >= 4 && n <= 15) ? 32'd1 : 32'd0);
      if (n == 1) begin
        cs_n = 1'b1; rd_n = 1'b1;
        sel_chan = 3'd2; sel_diff = 1'b0; sel_bip = 1'b1;
      end
      if (n == 2) begin
        chk("R3 chan", {29'd0, conv_chan}, 32'd5);
        chk("R3 diff", {31'd0, conv_diff}, 32'd1);
        chk("R3 bip", {31'd0, conv_bip}, 32'd0);
        chk("R8 pipelined rdy_n", {31'd0, rdy_n}, 32'd1);
      end
      if (n == 5) begin
        cs_n = 1'b0; rd_n = 1'b0;
        #1 chk("R5 start_ovr", {31'd0, start_ovr}, 32'd1);
      end
      if (n == 6) begin cs_n = 1'b1; rd_n = 1'b1; end
      if (n == 16) chk("R5 R3 chan kept", {29'd0, conv_chan}, 32'd5);
    end

    // second pipelined read returns first result (R7, R2)
    idle_gap();
    target = 12'h3F1;
    start_read(12'hA5C, 12'hFFF, "R7 R2 previous result");
    finish_conv();

    // high-byte read: no start (R4), format (R6)
    idle_gap();
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
    expect_read(12'h303, 12'hFFF, "R6 high byte");
    for (int n = 1; n <= 3; n++) begin
      cyc();
      chk("R4 no start on hben", {31'd0, busy_n}, 32'd1);
    end
    idle_gap();

    // two-byte pipelined sequence (R10)
    target = 12'h80F;
    start_read(12'h0F1, 12'h0FF, "R10 previous low byte");
    finish_conv();
    idle_gap();
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
    expect_read(12'h808, 12'hFFF, "R10 new upper nibble");
    cyc();
    idle_gap();
    target = 12'hFFF;
    start_read(12'h00F, 12'h0FF, "R10 new low byte");
    cyc();
    chk("R10 low read starts", {31'd0, busy_n}, 32'd0);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (16) cyc();

    // wait-state mode (R8) with mode change during conversion (R9)
    wait_mode = 1'b1;
    cyc();
    target = 12'h001;
    cs_n = 1'b0;
    #1 chk("R8 rdy low on select", {31'd0, rdy_n}, 32'd0);
    cyc();
    rd_n = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      cyc();
      if (n == 1) chk("R7 old data during conversion", {20'd0, dout}, 32'hFFF);
      if (n == 3) wait_mode = 1'b0;
      if (n <= 15) chk("R8 R9 rdy stalls", {31'd0, rdy_n}, 32'd0);
      else begin
        chk("R8 rdy released", {31'd0, rdy_n}, 32'd1);
        chk("R8 busy with rdy", {31'd0, busy_n}, 32'd1);
        chk("R8 fresh result", {20'd0, dout}, 32'h001);
      end
    end
    cs_n = 1'b1; rd_n = 1'b1;
    cyc();
    cyc();
    cs_n = 1'b0;
    #1 chk("R9 new mode after idle", {31'd0, rdy_n}, 32'd1);
    cyc();
    cs_n = 1'b1;
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule